// File: doc/BRIEF.md
# Processor exception entry controller

This block sits next to a simple processor core and, each time the core reports an instruction boundary, decides whether to enter a fast interrupt, a normal interrupt, or neither. Each of the two request inputs is active low and asynchronous. Each one passes through its own reset-to-inactive synchronizer before the decision sees it. The decision also depends on the two mask bits held in the status register that this block owns.

When it enters an exception, the block switches the processor mode. It saves a return address and the old status into a link/saved-status pair that belongs to the new mode. It sets the mask bits the new mode requires and hands the vector address to the core's program counter. A return strobe reverses the entry: it restores the status from the current mode's saved copy and hands back the resume address. Software may also write the status register. While the core is in user mode, such a write cannot change either mask bit.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request is acted on only in a cycle where `boundary_i` is high. It counts as pending when its synchronized level is low, and the synchronizer has two stages. A request line must therefore be low before two rising edges ahead of the boundary edge. A cycle with neither `boundary_i` nor `ret_i` produces no `pc_load_o` and no taken flag.
- R2: A fast interrupt is taken only while the F bit (status bit 6) is 0. A normal interrupt is taken only while the I bit (status bit 7) is 0.
- R3: When both requests are pending and unmasked, the fast interrupt wins. At most one of `take_fiq_o` and `take_irq_o` is high in any cycle.
- R4: Fast-interrupt entry sets mode bits [4:0] to 5'b10001 and sets both F and I. It loads the program counter with 0x1C and pulses `take_fiq_o` for one cycle.
- R5: Normal-interrupt entry sets mode bits [4:0] to 5'b10010 and sets I. It leaves F unchanged, loads the program counter with 0x18 and pulses `take_irq_o` for one cycle.
- R6: On entry, the link register of the entered mode receives `next_addr_i` + 4 and that mode's saved status receives the status held before entry. The other mode's pair is untouched.
- R7: A return while in mode 5'b10001 or 5'b10010 loads the program counter with that mode's link value minus 4 and copies that mode's saved status into the status register.
- R8: A status write replaces every bit with `sr_wdata_i`, except in user mode (mode bits 5'b10000), where bits 6 and 7 keep their old values.
- R9: At a boundary with no exception taken, `pc_o` becomes `next_addr_i`, `pc_load_o` pulses, and neither taken flag rises.
- R10: After reset the status register reads 0x000000D3 (mode 5'b10011, F and I set). The link and saved-status registers read 0, and `pc_load_o` and both taken flags are low.
- R11: Only one operation acts per cycle, with a return ahead of a boundary and a boundary ahead of a status write. A return in a mode other than 5'b10001 or 5'b10010 changes nothing and loads no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fiq_n_i | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_n_i | input | 1 | Normal interrupt request, active low, asynchronous |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| next_addr_i | input | DATA_W | Address of the next instruction |
| ret_i | input | 1 | Return-from-exception strobe |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | DATA_W | Status register write data |
| sr_o | output | DATA_W | Current status register |
| pc_o | output | DATA_W | Address to load into the program counter |
| pc_load_o | output | 1 | One-cycle pulse: `pc_o` is valid |
| take_fiq_o | output | 1 | One-cycle pulse: fast interrupt entered |
| take_irq_o | output | 1 | One-cycle pulse: normal interrupt entered |
| fiq_lr_o | output | DATA_W | Fast-mode link register |
| fiq_spsr_o | output | DATA_W | Fast-mode saved status |
| irq_lr_o | output | DATA_W | Normal-mode link register |
| irq_spsr_o | output | DATA_W | Normal-mode saved status |

## Verification
Every output is registered, so the result of a boundary, return or status write is visible one clock after the edge that samples the strobe. A change on a request line, however, reaches the decision only at the third rising edge after it is driven. The bench drives its inputs on falling edges and advances a behavioural model on rising edges. It compares that model with all outputs on the next falling edge, which is exactly one edge later. Directed checks sample on that same falling edge. For the synchronizer latency, the bench issues three boundaries in a row right after a request falls and expects only the third to enter the exception.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

    localparam int MODE_W   = 5;
    localparam int BIT_F    = 6;
    localparam int BIT_I    = 7;
    localparam int LINK_OFS = 4;
    localparam int VEC_FIQ  = 'h1C;
    localparam int VEC_IRQ  = 'h18;

    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ  = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ  = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;

    localparam int BANK_FIQ = 0;
    localparam int BANK_IRQ = 1;
    localparam int NBANKS   = 2;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_IRQ  = 2'd1,
        EXC_FIQ  = 2'd2
    } exc_kind_e;

endpackage

// File: rtl/exc_sync.sv
`timescale 1ns/1ps
module exc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q << 1;
        chain_d[0] = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      boundary_i,
    input  logic      fiq_req_i,
    input  logic      irq_req_i,
    input  logic      f_mask_i,
    input  logic      i_mask_i,
    output exc_kind_e kind_o
);

    always_comb begin
        kind_o = EXC_NONE;
        if (boundary_i) begin
            if (fiq_req_i && !f_mask_i)      kind_o = EXC_FIQ;
            else if (irq_req_i && !i_mask_i) kind_o = EXC_IRQ;
        end
    end

endmodule

// File: rtl/exc_bank.sv
`timescale 1ns/1ps
module exc_bank #(
    parameter int DATA_W = 32,
    parameter int BANKS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BANKS-1:0]              we_i,
    input  logic [DATA_W-1:0]             lr_i,
    input  logic [DATA_W-1:0]             sr_i,
    output logic [BANKS-1:0][DATA_W-1:0]  lr_o,
    output logic [BANKS-1:0][DATA_W-1:0]  sr_o
);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] lr_d, lr_q, sr_d, sr_q;

        always_comb begin
            lr_d = lr_q;
            sr_d = sr_q;
            if (we_i[g]) begin
                lr_d = lr_i;
                sr_d = sr_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lr_q <= '0;
                sr_q <= '0;
            end else begin
                lr_q <= lr_d;
                sr_q <= sr_d;
            end
        end

        assign lr_o[g] = lr_q;
        assign sr_o[g] = sr_q;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_n_i,
    input  logic              irq_n_i,
    input  logic              boundary_i,
    input  logic [DATA_W-1:0] next_addr_i,
    input  logic              ret_i,
    input  logic              sr_wr_i,
    input  logic [DATA_W-1:0] sr_wdata_i,
    output logic [DATA_W-1:0] sr_o,
    output logic [DATA_W-1:0] pc_o,
    output logic              pc_load_o,
    output logic              take_fiq_o,
    output logic              take_irq_o,
    output logic [DATA_W-1:0] fiq_lr_o,
    output logic [DATA_W-1:0] fiq_spsr_o,
    output logic [DATA_W-1:0] irq_lr_o,
    output logic [DATA_W-1:0] irq_spsr_o
);

    localparam int NLINES = 2;
    localparam logic [DATA_W-1:0] SR_RST =
        DATA_W'({1'b1, 1'b1, 1'b0, MODE_SVC});

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] pc;
        logic              pc_load;
        logic              take_fiq;
        logic              take_irq;
    } state_t;

    state_t st_d, st_q;

    // synchronizers: line 0 = fast, line 1 = normal
    logic [NLINES-1:0] line_n, line_sync_n;
    assign line_n = {irq_n_i, fiq_n_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        exc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (line_n[g]),
            .q_o   (line_sync_n[g])
        );
    end

    exc_kind_e kind;

    exc_arbiter u_arb (
        .boundary_i (boundary_i && !ret_i),
        .fiq_req_i  (!line_sync_n[0]),
        .irq_req_i  (!line_sync_n[1]),
        .f_mask_i   (st_q.sr[BIT_F]),
        .i_mask_i   (st_q.sr[BIT_I]),
        .kind_o     (kind)
    );

    logic [NBANKS-1:0]             bank_we;
    logic [NBANKS-1:0][DATA_W-1:0] bank_lr, bank_sr;
    logic [DATA_W-1:0]             link_val;

    assign link_val = next_addr_i + DATA_W'(LINK_OFS);

    exc_bank #(.DATA_W(DATA_W), .BANKS(NBANKS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (bank_we),
        .lr_i  (link_val),
        .sr_i  (st_q.sr),
        .lr_o  (bank_lr),
        .sr_o  (bank_sr)
    );

    logic [MODE_W-1:0] cur_mode;
    assign cur_mode = st_q.sr[MODE_W-1:0];

    always_comb begin
        st_d          = st_q;
        st_d.pc_load  = 1'b0;
        st_d.take_fiq = 1'b0;
        st_d.take_irq = 1'b0;
        bank_we       = '0;

        if (ret_i) begin
            if (cur_mode == MODE_FIQ) begin
                st_d.pc      = bank_lr[BANK_FIQ] - DATA_W'(LINK_OFS);
                st_d.sr      = bank_sr[BANK_FIQ];
                st_d.pc_load = 1'b1;
            end else if (cur_mode == MODE_IRQ) begin
                st_d.pc      = bank_lr[BANK_IRQ] - DATA_W'(LINK_OFS);
                st_d.sr      = bank_sr[BANK_IRQ];
                st_d.pc_load = 1'b1;
            end
        end else if (boundary_i) begin
            st_d.pc_load = 1'b1;
            unique case (kind)
                EXC_FIQ: begin
                    bank_we[BANK_FIQ]         = 1'b1;
                    st_d.sr[MODE_W-1:0]       = MODE_FIQ;
                    st_d.sr[BIT_F]            = 1'b1;
                    st_d.sr[BIT_I]            = 1'b1;
                    st_d.pc                   = DATA_W'(VEC_FIQ);
                    st_d.take_fiq             = 1'b1;
                end
                EXC_IRQ: begin
                    bank_we[BANK_IRQ]         = 1'b1;
                    st_d.sr[MODE_W-1:0]       = MODE_IRQ;
                    st_d.sr[BIT_I]            = 1'b1;
                    st_d.pc                   = DATA_W'(VEC_IRQ);
                    st_d.take_irq             = 1'b1;
                end
                default: begin
                    st_d.pc = next_addr_i;
                end
            endcase
        end else if (sr_wr_i) begin
            st_d.sr = sr_wdata_i;
            if (cur_mode == MODE_USER) begin
                st_d.sr[BIT_F] = st_q.sr[BIT_F];
                st_d.sr[BIT_I] = st_q.sr[BIT_I];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr       <= SR_RST;
            st_q.pc       <= '0;
            st_q.pc_load  <= 1'b0;
            st_q.take_fiq <= 1'b0;
            st_q.take_irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o       = st_q.sr;
    assign pc_o       = st_q.pc;
    assign pc_load_o  = st_q.pc_load;
    assign take_fiq_o = st_q.take_fiq;
    assign take_irq_o = st_q.take_irq;
    assign fiq_lr_o   = bank_lr[BANK_FIQ];
    assign fiq_spsr_o = bank_sr[BANK_FIQ];
    assign irq_lr_o   = bank_lr[BANK_IRQ];
    assign irq_spsr_o = bank_sr[BANK_IRQ];

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              ret_i,
    input logic [DATA_W-1:0] next_addr_i,
    input logic [DATA_W-1:0] sr_o,
    input logic [DATA_W-1:0] pc_o,
    input logic              pc_load_o,
    input logic              take_fiq_o,
    input logic              take_irq_o,
    input logic [DATA_W-1:0] fiq_lr_o,
    input logic [DATA_W-1:0] fiq_spsr_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary_i && !ret_i) |=> (!pc_load_o && !take_fiq_o && !take_irq_o));

    assert_fiq_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq_o |-> !$past(sr_o[6]));

    assert_irq_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> !$past(sr_o[7]));

    assert_single_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_fiq_o, take_irq_o}));

    assert_fiq_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq_o |-> (sr_o[4:0] == 5'b10001 && sr_o[7:6] == 2'b11 &&
                        pc_o == DATA_W'(32'h1C) && pc_load_o));

    assert_irq_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> (sr_o[4:0] == 5'b10010 && sr_o[7] &&
                        sr_o[6] == $past(sr_o[6]) && pc_o == DATA_W'(32'h18)));

    assert_fiq_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq_o |-> (fiq_lr_o == $past(next_addr_i) + DATA_W'(4) &&
                        fiq_spsr_o == $past(sr_o)));

    assert_fiq_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && sr_o[4:0] == 5'b10001) |=>
            (pc_load_o && pc_o == $past(fiq_lr_o) - DATA_W'(4) &&
             sr_o == $past(fiq_spsr_o)));

    assert_user_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_o[4:0] == 5'b10000 && !boundary_i && !ret_i) |=>
            (sr_o[7:6] == $past(sr_o[7:6])));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .ret_i       (ret_i),
    .next_addr_i (next_addr_i),
    .sr_o        (sr_o),
    .pc_o        (pc_o),
    .pc_load_o   (pc_load_o),
    .take_fiq_o  (take_fiq_o),
    .take_irq_o  (take_irq_o),
    .fiq_lr_o    (fiq_lr_o),
    .fiq_spsr_o  (fiq_spsr_o)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_n = 1'b1, irq_n = 1'b1;
    logic        bnd = 1'b0, ret = 1'b0, wr = 1'b0;
    logic [31:0] wdata = '0, nxt = '0;
    logic [31:0] sr, pc, flr, fsp, ilr, isp;
    logic        pld, tf, ti;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .fiq_n_i (fiq_n), .irq_n_i (irq_n),
        .boundary_i (bnd), .next_addr_i (nxt), .ret_i (ret),
        .sr_wr_i (wr), .sr_wdata_i (wdata),
        .sr_o (sr), .pc_o (pc), .pc_load_o (pld),
        .take_fiq_o (tf), .take_irq_o (ti),
        .fiq_lr_o (flr), .fiq_spsr_o (fsp), .irq_lr_o (ilr), .irq_spsr_o (isp)
    );

    int checks = 0, fails = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_sr, m_pc, m_flr, m_fsp, m_ilr, m_isp;
    bit m_ld, m_tf, m_ti, f1, f2, i1, i2;

    always @(posedge clk) begin : model
        bit pf, pi;
        if (!rst_n) begin
            m_sr = 32'hD3; m_pc = 0; m_flr = 0; m_fsp = 0; m_ilr = 0; m_isp = 0;
            m_ld = 0; m_tf = 0; m_ti = 0; f1 = 1; f2 = 1; i1 = 1; i2 = 1;
        end else begin
            pf = !f2 && !m_sr[6];
            pi = !i2 && !m_sr[7];
            m_ld = 0; m_tf = 0; m_ti = 0;
            if (ret) begin
                if (m_sr[4:0] == 5'h11) begin
                    m_pc = m_flr - 4; m_sr = m_fsp; m_ld = 1;
                end else if (m_sr[4:0] == 5'h12) begin
                    m_pc = m_ilr - 4; m_sr = m_isp; m_ld = 1;
                end
            end else if (bnd) begin
                m_ld = 1;
                if (pf) begin
                    m_flr = nxt + 4; m_fsp = m_sr;
                    m_sr = {m_sr[31:8], 2'b11, m_sr[5], 5'h11};
                    m_pc = 32'h1C; m_tf = 1;
                end else if (pi) begin
                    m_ilr = nxt + 4; m_isp = m_sr;
                    m_sr = {m_sr[31:8], 1'b1, m_sr[6:5], 5'h12};
                    m_pc = 32'h18; m_ti = 1;
                end else begin
                    m_pc = nxt;
                end
            end else if (wr) begin
                if (m_sr[4:0] == 5'h10) m_sr = {wdata[31:8], m_sr[7:6], wdata[5:0]};
                else                    m_sr = wdata;
            end
            f2 = f1; f1 = fiq_n; i2 = i1; i1 = irq_n;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 model sr", sr, m_sr);
            chk("R1 model pc_load", {31'b0, pld}, {31'b0, m_ld});
            chk("R3 model take_fiq", {31'b0, tf}, {31'b0, m_tf});
            chk("R3 model take_irq", {31'b0, ti}, {31'b0, m_ti});
            chk("R6 model fiq_lr", flr, m_flr);
            chk("R6 model fiq_spsr", fsp, m_fsp);
            chk("R6 model irq_lr", ilr, m_ilr);
            chk("R6 model irq_spsr", isp, m_isp);
            if (m_ld) chk("R9 model pc", pc, m_pc);
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic boundary(logic [31:0] a);
        @(negedge clk); bnd = 1; nxt = a;
        @(negedge clk); bnd = 0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret = 1;
        @(negedge clk); ret = 0;
    endtask

    task automatic do_wr(logic [31:0] d);
        @(negedge clk); wr = 1; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 sr", sr, 32'hD3);
        chk("R10 pc_load", {31'b0, pld}, 32'h0);
        chk("R10 taken", {30'b0, tf, ti}, 32'h0);
        chk("R10 banks", flr | fsp | ilr | isp, 32'h0);

        do_wr(32'h13);
        chk("R8 svc write", sr, 32'h13);

        boundary(32'h100);
        chk("R9 pc passthrough", pc, 32'h100);
        chk("R9 no taken", {30'b0, tf, ti}, 32'h0);

        irq_n = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 no load without boundary", {31'b0, pld}, 32'h0);
        end
        boundary(32'h200);
        chk("R5 irq taken", {31'b0, ti}, 32'h1);
        chk("R5 irq sr", sr, 32'h92);
        chk("R5 irq vector", pc, 32'h18);
        chk("R6 irq link", ilr, 32'h204);
        chk("R6 irq saved", isp, 32'h13);

        fiq_n = 0; idle(3);
        boundary(32'h300);
        chk("R4 fiq taken", {31'b0, tf}, 32'h1);
        chk("R4 fiq sr", sr, 32'hD1);
        chk("R4 fiq vector", pc, 32'h1C);
        chk("R6 fiq link", flr, 32'h304);
        chk("R6 fiq saved", fsp, 32'h92);
        chk("R6 irq bank untouched", ilr, 32'h204);

        fiq_n = 1; irq_n = 1; idle(3);
        do_ret();
        chk("R7 fiq return sr", sr, 32'h92);
        chk("R7 fiq return pc", pc, 32'h300);

        @(negedge clk); ret = 1; bnd = 1; nxt = 32'h999;
        @(negedge clk); ret = 0; bnd = 0;
        chk("R11 return beats boundary pc", pc, 32'h200);
        chk("R11 return beats boundary sr", sr, 32'h13);

        fiq_n = 0; irq_n = 0; idle(3);
        boundary(32'h400);
        chk("R3 fiq wins", {30'b0, tf, ti}, 32'h2);
        chk("R3 fiq sr", sr, 32'hD1);
        do_ret();
        chk("R7 second return", sr, 32'h13);

        do_wr(32'h53);
        boundary(32'h500);
        chk("R2 F masks fiq", {30'b0, tf, ti}, 32'h1);
        chk("R5 F kept", sr, 32'hD2);
        do_ret();
        chk("R7 irq return", pc, 32'h500);

        do_wr(32'hD3);
        boundary(32'h600);
        chk("R2 both masked", {30'b0, tf, ti}, 32'h0);
        chk("R2 both masked pc", pc, 32'h600);

        fiq_n = 1; irq_n = 1;
        do_wr(32'h13); idle(3);
        @(negedge clk); irq_n = 0; bnd = 1; nxt = 32'h700;
        @(negedge clk); nxt = 32'h704;
        chk("R1 sync stage one", {31'b0, ti}, 32'h0);
        @(negedge clk); nxt = 32'h708;
        chk("R1 sync stage two", {31'b0, ti}, 32'h0);
        @(negedge clk); bnd = 0;
        chk("R1 sync taken", {31'b0, ti}, 32'h1);
        chk("R6 link after sync", ilr, 32'h70C);
        irq_n = 1; idle(3);
        do_ret();

        do_wr(32'hD0);
        chk("R8 enter user", sr, 32'hD0);
        do_wr(32'h0000AB10);
        chk("R8 user mask bits held", sr, 32'h0000ABD0);
        do_ret();
        chk("R11 user return ignored sr", sr, 32'h0000ABD0);
        chk("R11 user return no load", {31'b0, pld}, 32'h0);

        idle(2);
        summary();
    end

endmodule